// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source and destination addresses for one DMA channel that holds two sub-channels, A and B. Each sub-channel owns a 24-bit memory pointer that steps after every transfer, and a 16-bit I/O pointer that stays fixed. On the 24-bit bus, the I/O pointer appears with its top byte forced to 0xFF. Software loads all six registers through a simple 16-bit register port. Every register can be read back through the same port.

The block has two pairing modes. In short mode, one sub-channel is selected. Its direction bit decides whether its memory pointer is the source and its I/O pointer the destination, or the other way round. In full mode, memory pointer A is always the source and memory pointer B is always the destination, and both step after each transfer. Each pointer has its own step control: increment, decrement or hold. The step is one byte or two bytes, and arithmetic wraps modulo 2^24. A register write always wins over a step that lands in the same cycle.

The address registers have no reset value. Reset only freezes them: while reset is asserted, writes and transfer strobes are ignored.

Top module: `dma_addr_gen`

## Requirements
- R1: `reg_sel` selects the register. Code 0 is the high half of memory pointer A, 1 its low half, 2 the high half of memory pointer B, 3 its low half, 4 I/O pointer A and 5 I/O pointer B. A write with `reg_wr`=1 takes effect at the next rising edge. `reg_rdata` shows the selected register combinationally, and codes 6 and 7 read as 0.
- R2: A high-half register stores only `reg_wdata[7:0]`, which become address bits 23:16. Its bits 15:8 always read as 0.
- R3: In short mode (`full_mode`=0), `sel_b`=0 selects sub-channel A and `sel_b`=1 selects sub-channel B. With the selected direction bit at 0, the memory pointer is `src_addr` and the I/O address is `dst_addr`. With it at 1, the two are swapped.
- R4: The I/O address is {0xFF, I/O pointer}. The I/O pointer never changes because of a transfer.
- R5: When `xfer_done`=1 at a rising edge, each stepping pointer changes according to its 2-bit step code: 01 adds the size, 10 subtracts it, and 00 or 11 holds. The size is 2 when `xfer_word`=1 and 1 otherwise. The new address is visible on the outputs after that edge.
- R6: In short mode, only the selected sub-channel's memory pointer steps. The other memory pointer keeps its value.
- R7: In full mode, `src_addr` is memory pointer A and `dst_addr` is memory pointer B, whatever `sel_b`, `dir_a` and `dir_b` are. Both pointers step on each transfer, each with its own step code.
- R8: A step wraps modulo 2^24. For example, 0xFFFFFF plus 1 gives 0x000000, and 0x000000 minus 2 gives 0xFFFFFE.
- R9: If a write to either half of a memory pointer arrives in the same cycle as a transfer, the written value is stored and that pointer's step is dropped. The other pointer steps normally.
- R10: No address register is cleared by reset. While `rst_n`=0, writes and transfers have no effect and every register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; freezes the registers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| full_mode | input | 1 | 1 = full mode, 0 = short mode |
| sel_b | input | 1 | Short mode: active sub-channel (0 = A, 1 = B) |
| dir_a | input | 1 | Sub-channel A direction (1 = I/O is source) |
| dir_b | input | 1 | Sub-channel B direction (1 = I/O is source) |
| step_mode_a | input | 2 | Step code for memory pointer A |
| step_mode_b | input | 2 | Step code for memory pointer B |
| xfer_done | input | 1 | Transfer completed this cycle |
| xfer_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| src_addr | output | 24 | Source address |
| dst_addr | output | 24 | Destination address |

## Verification
The bench builds the block with its default widths: a 24-bit address and a 16-bit register port. These are the only widths at which the 0xFF I/O top byte and the 8-bit high half exist as specified. With these widths, a few register writes can place a pointer at 0xFFFFFF or 0x000000, so both wrap directions are reached within a few transfers. Collisions between a write and a step are reached by driving both in one cycle.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_INC   = 2'b01,
    STEP_DEC   = 2'b10,
    STEP_HOLD2 = 2'b11
  } step_e;

  // register select codes
  localparam logic [SEL_W-1:0] SEL_MA_HI = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MA_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MB_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MB_LO = 3'd3;
  localparam logic [SEL_W-1:0] SEL_IO_A  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IO_B  = 3'd5;
endpackage

// File: rtl/dma_mem_ptr.sv
module dma_mem_ptr #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              step_go,
  input  logic [1:0]        step_mode,
  input  logic              step_word,
  output logic [ADDR_W-1:0] ptr_q
);
  import dma_ag_pkg::*;
  localparam int HI_W = ADDR_W - BUS_W;

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] cur, input logic [1:0] mode, input logic word);
    logic [ADDR_W-1:0] size;
    size = word ? ADDR_W'(2) : ADDR_W'(1);
    case (step_e'(mode))
      STEP_INC: step_addr = cur + size;
      STEP_DEC: step_addr = cur - size;
      default:  step_addr = cur;
    endcase
  endfunction

  // no reset value: reset only freezes the pointer
  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (wr_hi || wr_lo) begin
        if (wr_hi) ptr_q[ADDR_W-1:BUS_W] <= wr_data[HI_W-1:0];
        if (wr_lo) ptr_q[BUS_W-1:0]      <= wr_data;
      end else if (step_go) begin
        ptr_q <= step_addr(ptr_q, step_mode, step_word);
      end
    end
  end
endmodule

// File: rtl/dma_io_ptr.sv
module dma_io_ptr #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - BUS_W;
  logic [BUS_W-1:0] io_q;

  function automatic logic [ADDR_W-1:0] io_form(input logic [BUS_W-1:0] lo);
    io_form = {{HI_W{1'b1}}, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (rst_n && wr_en) io_q <= wr_data;
  end

  assign addr_q = io_form(io_q);
endmodule

// File: rtl/dma_route.sv
module dma_route #(
  parameter int ADDR_W = 24
) (
  input  logic              full_mode,
  input  logic              sel_b,
  input  logic              dir_a,
  input  logic              dir_b,
  input  logic              xfer_done,
  input  logic [ADDR_W-1:0] mem_a,
  input  logic [ADDR_W-1:0] mem_b,
  input  logic [ADDR_W-1:0] io_a,
  input  logic [ADDR_W-1:0] io_b,
  output logic [1:0]        step_go,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  logic              dir_s;
  logic [ADDR_W-1:0] mem_s, io_s;

  assign dir_s = sel_b ? dir_b : dir_a;
  assign mem_s = sel_b ? mem_b : mem_a;
  assign io_s  = sel_b ? io_b  : io_a;

  always_comb begin
    if (full_mode) begin
      src_addr = mem_a;
      dst_addr = mem_b;
      step_go  = {2{xfer_done}};
    end else begin
      src_addr = dir_s ? io_s  : mem_s;
      dst_addr = dir_s ? mem_s : io_s;
      step_go  = {sel_b & xfer_done, ~sel_b & xfer_done};
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              full_mode,
  input  logic              sel_b,
  input  logic              dir_a,
  input  logic              dir_b,
  input  logic [1:0]        step_mode_a,
  input  logic [1:0]        step_mode_b,
  input  logic              xfer_done,
  input  logic              xfer_word,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  import dma_ag_pkg::*;
  localparam int HI_W = ADDR_W - BUS_W;
  localparam int NSUB = 2;

  logic [NSUB-1:0]   wr_hi, wr_lo, wr_io, step_go;
  logic [1:0]        step_mode [NSUB];
  logic [ADDR_W-1:0] mem_q [NSUB];
  logic [ADDR_W-1:0] io_addr [NSUB];

  assign step_mode[0] = step_mode_a;
  assign step_mode[1] = step_mode_b;

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    localparam logic [2:0] HI_CODE = 3'(2 * g);
    localparam logic [2:0] LO_CODE = 3'(2 * g + 1);
    localparam logic [2:0] IO_CODE = 3'(4 + g);

    assign wr_hi[g] = reg_wr && (reg_sel == HI_CODE);
    assign wr_lo[g] = reg_wr && (reg_sel == LO_CODE);
    assign wr_io[g] = reg_wr && (reg_sel == IO_CODE);

    dma_mem_ptr #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi[g]), .wr_lo(wr_lo[g]),
      .wr_data(reg_wdata), .step_go(step_go[g]), .step_mode(step_mode[g]),
      .step_word(xfer_word), .ptr_q(mem_q[g]));

    dma_io_ptr #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_io (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_io[g]), .wr_data(reg_wdata),
      .addr_q(io_addr[g]));
  end

  dma_route #(.ADDR_W(ADDR_W)) u_route (
    .full_mode(full_mode), .sel_b(sel_b), .dir_a(dir_a), .dir_b(dir_b),
    .xfer_done(xfer_done), .mem_a(mem_q[0]), .mem_b(mem_q[1]),
    .io_a(io_addr[0]), .io_b(io_addr[1]), .step_go(step_go),
    .src_addr(src_addr), .dst_addr(dst_addr));

  always_comb begin
    case (reg_sel)
      SEL_MA_HI: reg_rdata = {{(BUS_W-HI_W){1'b0}}, mem_q[0][ADDR_W-1:BUS_W]};
      SEL_MA_LO: reg_rdata = mem_q[0][BUS_W-1:0];
      SEL_MB_HI: reg_rdata = {{(BUS_W-HI_W){1'b0}}, mem_q[1][ADDR_W-1:BUS_W]};
      SEL_MB_LO: reg_rdata = mem_q[1][BUS_W-1:0];
      SEL_IO_A:  reg_rdata = io_addr[0][BUS_W-1:0];
      SEL_IO_B:  reg_rdata = io_addr[1][BUS_W-1:0];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [BUS_W-1:0]  reg_wdata,
  input logic [BUS_W-1:0]  reg_rdata,
  input logic              full_mode,
  input logic              sel_b,
  input logic              dir_a,
  input logic              dir_b,
  input logic [1:0]        step_mode_a,
  input logic              xfer_done,
  input logic              xfer_word,
  input logic              wr_hit_a,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr
);
  localparam int HI_W = ADDR_W - BUS_W;

  function automatic logic [ADDR_W-1:0] plus(input logic [ADDR_W-1:0] a, input logic w);
    plus = a + (w ? ADDR_W'(2) : ADDR_W'(1));
  endfunction

  logic io_dst_now;
  assign io_dst_now = !full_mode && ((sel_b ? dir_b : dir_a) == 1'b0);

  // R2
  hi_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 3'd0 || reg_sel == 3'd2) |-> reg_rdata[BUS_W-1:HI_W] == '0);

  // R4
  io_top_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_dst_now |-> dst_addr[ADDR_W-1:BUS_W] == {HI_W{1'b1}});

  // R7
  full_src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(full_mode) && full_mode && $past(xfer_done) &&
     !$past(wr_hit_a) && $past(step_mode_a) == 2'b01)
    |-> src_addr == plus($past(src_addr), $past(xfer_word)));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr) && $past(reg_sel) == 3'd1 &&
     $past(full_mode) && full_mode)
    |-> src_addr[BUS_W-1:0] == $past(reg_wdata));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(full_mode) && full_mode && !$past(wr_hit_a) &&
     ($past(step_mode_a) == 2'b00 || $past(step_mode_a) == 2'b11))
    |-> src_addr == $past(src_addr));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .full_mode(full_mode),
  .sel_b(sel_b), .dir_a(dir_a), .dir_b(dir_b), .step_mode_a(step_mode_a),
  .xfer_done(xfer_done), .xfer_word(xfer_word),
  .wr_hit_a(wr_hi[0] | wr_lo[0]), .src_addr(src_addr), .dst_addr(dst_addr));

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        full_mode = 1'b0, sel_b = 1'b0, dir_a = 1'b0, dir_b = 1'b0;
  logic [1:0]  step_mode_a = 2'b00, step_mode_b = 2'b00;
  logic        xfer_done = 1'b0, xfer_word = 1'b0;
  logic [23:0] src_addr, dst_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [23:0] m_a, m_b;
  logic [15:0] i_a, i_b;

  always #10 clk = ~clk;

  dma_addr_gen u_dut (.*);

  function automatic logic [23:0] mstep(input logic [23:0] v, input logic [1:0] md, input logic w);
    logic [23:0] d;
    d = w ? 24'd2 : 24'd1;
    if (md == 2'b01) return v + d;
    if (md == 2'b10) return v - d;
    return v;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (rst_n) case (s)
      3'd0: m_a[23:16] = d[7:0];
      3'd1: m_a[15:0]  = d;
      3'd2: m_b[23:16] = d[7:0];
      3'd3: m_b[15:0]  = d;
      3'd4: i_a = d;
      3'd5: i_b = d;
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input logic [2:0] s, input logic [15:0] exp);
    reg_sel = s;
    #1;
    chk(req, {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  task automatic xfer(input logic w);
    @(negedge clk);
    xfer_done = 1'b1; xfer_word = w;
    @(negedge clk);
    xfer_done = 1'b0;
    if (full_mode) begin
      m_a = mstep(m_a, step_mode_a, w);
      m_b = mstep(m_b, step_mode_b, w);
    end else if (sel_b) m_b = mstep(m_b, step_mode_b, w);
    else m_a = mstep(m_a, step_mode_a, w);
  endtask

  task automatic t_init;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wr(3'd0, 16'hAB12); wr(3'd1, 16'h3456);
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
    wr(3'd4, 16'hBEEF); wr(3'd5, 16'h0100);
    rd("R2 hi half upper byte zero", 3'd0, 16'h0012);
    rd("R1 memA lo", 3'd1, 16'h3456);
    rd("R1 memB hi", 3'd2, 16'h0000);
    rd("R1 ioA", 3'd4, 16'hBEEF);
    rd("R1 ioB", 3'd5, 16'h0100);
    rd("R1 unused code 6", 3'd6, 16'h0000);
    rd("R1 unused code 7", 3'd7, 16'h0000);
  endtask

  task automatic t_short_a;
    full_mode = 0; sel_b = 0; dir_a = 0; step_mode_a = 2'b01; step_mode_b = 2'b01;
    #1;
    chk("R3 short A dir0 src", src_addr, 24'h123456);
    chk("R4 short A dir0 dst io", dst_addr, 24'hFFBEEF);
    xfer(1'b0);
    chk("R5 byte inc", src_addr, 24'h123457);
    xfer(1'b1);
    chk("R5 word inc", src_addr, m_a);
    chk("R5 word inc value", m_a, 24'h123459);
    chk("R4 io fixed after transfers", dst_addr, 24'hFFBEEF);
    rd("R4 ioA readback", 3'd4, 16'hBEEF);
    rd("R6 memB untouched lo", 3'd3, 16'h0000);
  endtask

  task automatic t_short_dir;
    dir_a = 1; step_mode_a = 2'b10;
    #1;
    chk("R3 dir1 src io", src_addr, 24'hFFBEEF);
    chk("R3 dir1 dst mem", dst_addr, m_a);
    xfer(1'b1);
    chk("R5 word dec", dst_addr, 24'h123457);
  endtask

  task automatic t_short_b_wrap;
    wr(3'd2, 16'h00FF); wr(3'd3, 16'hFFFF);
    sel_b = 1; dir_b = 0; step_mode_b = 2'b01;
    #1;
    chk("R3 short B src", src_addr, 24'hFFFFFF);
    chk("R4 short B dst io", dst_addr, 24'hFF0100);
    xfer(1'b0);
    chk("R8 wrap up", src_addr, 24'h000000);
    rd("R8 R2 hi after wrap", 3'd2, 16'h0000);
    step_mode_b = 2'b10;
    xfer(1'b1);
    chk("R8 wrap down", src_addr, 24'hFFFFFE);
    rd("R6 memA kept while B steps", 3'd1, m_a[15:0]);
    chk("R6 memA model", m_a, 24'h123457);
  endtask

  task automatic t_hold;
    sel_b = 0; dir_a = 0; step_mode_a = 2'b00;
    xfer(1'b1);
    chk("R5 hold code 00", src_addr, 24'h123457);
    step_mode_a = 2'b11;
    xfer(1'b0);
    chk("R5 hold code 11", src_addr, 24'h123457);
  endtask

  task automatic t_full;
    full_mode = 1; dir_a = 1; dir_b = 1; sel_b = 1;
    step_mode_a = 2'b01; step_mode_b = 2'b10;
    #1;
    chk("R7 full src memA", src_addr, m_a);
    chk("R7 full dst memB", dst_addr, m_b);
    xfer(1'b1);
    chk("R7 full A stepped", src_addr, 24'h123459);
    chk("R7 full B stepped", dst_addr, 24'hFFFFFC);
  endtask

  task automatic t_prio;
    @(negedge clk);
    reg_wr = 1; reg_sel = 3'd1; reg_wdata = 16'h0F0F;
    xfer_done = 1; xfer_word = 1;
    @(negedge clk);
    reg_wr = 0; xfer_done = 0;
    m_a[15:0] = 16'h0F0F;
    m_b = mstep(m_b, step_mode_b, 1'b1);
    chk("R9 write wins over step", src_addr, 24'h120F0F);
    chk("R9 other pointer still steps", dst_addr, 24'hFFFFFA);
  endtask

  task automatic t_reset_hold;
    @(negedge clk);
    rst_n = 0;
    xfer(1'b1);
    wr(3'd1, 16'h5555);
    m_a = 24'h120F0F; m_b = 24'hFFFFFA;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 memA kept over reset", src_addr, 24'h120F0F);
    chk("R10 memB kept over reset", dst_addr, 24'hFFFFFA);
    rd("R10 ioB kept over reset", 3'd5, 16'h0100);
  endtask

  initial begin
    t_init;
    t_short_a;
    t_short_dir;
    t_short_b_wrap;
    t_hold;
    t_full;
    t_prio;
    t_reset_hold;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule